// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits on the CPU side of an interconnect and sorts every outgoing 32-bit address into one of eight programmable windows. Each window holds a base, a size mask, a target identifier and an attribute byte, and can be switched on or off. For a presented address, the block reports whether an enabled window covers it. If one does, it returns the winning window's number, target and attribute, together with a 64-bit address for the target side. If none does, it raises a miss flag.

Window sizes are powers of two in 64 KiB steps. The size is held as a thermometer mask: a run of ones from bit 0 upward, where each set bit doubles the window. The two lowest-numbered windows can also relocate accesses: the covered address bits are replaced from a remap-low register, and a remap-high register supplies the upper 32 bits of the result. Software programs all of this through a simple write port. A separate combinational helper turns a byte count into the matching size mask, so the mask for a region can be computed on the fly.

While a region is being moved, two windows may cover the same range. A fixed priority keeps decoding deterministic during that overlap.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled: any lookup gives lk_miss=1, lk_hit=0 and zero on lk_win, lk_target, lk_attr and lk_addr_out.
- R2: A write with wr_en=1 updates the register of window wr_win chosen by wr_sel (0 control, 1 base, 2 remap low, 3 remap high). Decoding sees the new value from the cycle after the clock edge that takes the write, and not before it. Control word layout: bit 0 enable, bits 7:1 target, bits 15:8 attribute, bits 31:16 size mask.
- R3: Window w hits an address when it is enabled and, on every bit position i of addr[31:16] where size mask bit i is zero, the address bit equals base bit 16+i. Base bits 15:0 are ignored.
- R4: The size mask is a run of ones starting at bit 0. n ones give a window of 64 KiB·2^n: 0x0000 is 64 KiB and 0x00FF is 16 MiB.
- R5: When several enabled windows hit, the one with the lowest number wins and drives lk_win, lk_target, lk_attr and lk_addr_out.
- R6: Windows 0 and 1 translate. lk_addr_out = {remap_high, (remap_low[31:16] & ~mask) | (addr[31:16] & mask), addr[15:0]}. Setting remap low equal to base and remap high to zero gives an unchanged address.
- R7: Windows 2 to 7 pass the address through zero-extended to 64 bits, and writes with wr_sel 2 or 3 to them have no effect.
- R8: On a miss, lk_hit=0, lk_miss=1 and lk_win, lk_target, lk_attr and lk_addr_out are all zero. On a hit, lk_miss=0.
- R9: Writing zero to a window's control register disables it from the next cycle on, whatever its base.
- R10: The size helper returns ceil(sz_bytes / 65536) − 1, rounded up to the next run of ones over bits 15:0. sz_bytes = 0 stands for 4 GiB and gives 0xFFFF.
- R11: Two windows programmed to the same base and target overlap safely. The lower one serves while enabled, and disabling it hands the range to the higher one on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window addressed by the write |
| wr_sel | input | 2 | Register select: 0 control, 1 base, 2 remap low, 3 remap high |
| wr_data | input | 32 | Write data |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | An enabled window covers lk_addr |
| lk_miss | output | 1 | No enabled window covers lk_addr |
| lk_win | output | 3 | Number of the winning window |
| lk_target | output | 7 | Target identifier of the winning window |
| lk_attr | output | 8 | Attribute byte of the winning window |
| lk_addr_out | output | 64 | Translated or zero-extended address |
| sz_bytes | input | 32 | Byte count for the size helper |
| sz_field | output | 16 | Thermometer size mask for sz_bytes |

## Verification
A corrupted size or base register shows up as a wrong hit or miss on addresses just inside or just outside a window's edge. Because lookups are combinational from the registers, this is visible in the cycle after the bad write. A lost enable or a broken priority chain changes lk_win on overlapping windows at once. A bad remap register shows only on windows 0 and 1, in the upper address bits. The stimulus therefore probes window edges, overlaps, disable hand-over and both remap halves. It also compares lookups against the expected result in the cycle before a write takes effect.

// File: rtl/awd_pkg.sv
package awd_pkg;
   // register selector on the write port
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_BASE = 2'd1,
      SEL_RLO  = 2'd2,
      SEL_RHI  = 2'd3
   } awd_sel_e;

   // control word field positions (enable, then target, then attribute)
   localparam int EN_BIT  = 0;
   localparam int TGT_LSB = 1;
endpackage

// File: rtl/awd_size_calc.sv
module awd_size_calc #(
   parameter int ADDR_W = 32,
   parameter int GRAN_W = 16
) (
   input  logic [ADDR_W-1:0]        bytes_i,
   output logic [ADDR_W-GRAN_W-1:0] mask_o
);
   localparam int SZ_W = ADDR_W - GRAN_W;

   logic [SZ_W-1:0] blocks_m1;
   logic            acc;

   // number of granules minus one; zero bytes wraps to the full space
   assign blocks_m1 = SZ_W'((bytes_i - ADDR_W'(1)) >> GRAN_W);

   // smear every set bit into all lower positions
   always_comb begin
      acc = 1'b0;
      for (int i = SZ_W - 1; i >= 0; i--) begin
         acc       = acc | blocks_m1[i];
         mask_o[i] = acc;
      end
   end
endmodule

// File: rtl/awd_window.sv
module awd_window
   import awd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int GRAN_W = 16,
   parameter int TGT_W  = 7,
   parameter int ATTR_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_ctrl,
   input  logic                     we_base,
   input  logic [ADDR_W-1:0]        wdata,
   input  logic [ADDR_W-GRAN_W-1:0] addr_hi,
   output logic                     hit,
   output logic [ADDR_W-GRAN_W-1:0] size_mask,
   output logic [TGT_W-1:0]         tgt,
   output logic [ATTR_W-1:0]        attr
);
   localparam int SZ_W     = ADDR_W - GRAN_W;
   localparam int ATTR_LSB = TGT_LSB + TGT_W;

   logic            en_q;
   logic [SZ_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         size_mask <= '0;
         tgt       <= '0;
         attr      <= '0;
      end else if (we_ctrl) begin
         en_q      <= wdata[EN_BIT];
         size_mask <= wdata[ADDR_W-1:GRAN_W];
         tgt       <= wdata[TGT_LSB +: TGT_W];
         attr      <= wdata[ATTR_LSB +: ATTR_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q <= '0;
      else if (we_base) base_q <= wdata[ADDR_W-1:GRAN_W];
   end

   // compare only the bits outside the window's span
   assign hit = en_q && (((addr_hi ^ base_q) & ~size_mask) == '0);
endmodule

// File: rtl/awd_remap.sv
module awd_remap #(
   parameter int ADDR_W = 32,
   parameter int GRAN_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_lo,
   input  logic                     we_hi,
   input  logic [ADDR_W-1:0]        wdata,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [ADDR_W-GRAN_W-1:0] size_mask,
   output logic [2*ADDR_W-1:0]      xaddr
);
   localparam int SZ_W = ADDR_W - GRAN_W;

   logic [SZ_W-1:0]   lo_q;
   logic [ADDR_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (we_lo) lo_q <= wdata[ADDR_W-1:GRAN_W];
         if (we_hi) hi_q <= wdata;
      end
   end

   assign xaddr = {hi_q,
                   (lo_q & ~size_mask) | (addr[ADDR_W-1:GRAN_W] & size_mask),
                   addr[GRAN_W-1:0]};
endmodule

// File: rtl/awd_select.sv
module awd_select #(
   parameter int NUM_WIN = 8,
   parameter int TGT_W   = 7,
   parameter int ATTR_W  = 8,
   parameter int XA_W    = 64
) (
   input  logic [NUM_WIN-1:0]             hit_v,
   input  logic [NUM_WIN-1:0][TGT_W-1:0]  tgt_v,
   input  logic [NUM_WIN-1:0][ATTR_W-1:0] attr_v,
   input  logic [NUM_WIN-1:0][XA_W-1:0]   xaddr_v,
   output logic                           any_o,
   output logic [$clog2(NUM_WIN)-1:0]     idx_o,
   output logic [TGT_W-1:0]               tgt_o,
   output logic [ATTR_W-1:0]              attr_o,
   output logic [XA_W-1:0]                xaddr_o
);
   localparam int IDX_W = $clog2(NUM_WIN);

   // walk from the top so the lowest hitting window is written last
   always_comb begin
      any_o   = 1'b0;
      idx_o   = '0;
      tgt_o   = '0;
      attr_o  = '0;
      xaddr_o = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_v[i]) begin
            any_o   = 1'b1;
            idx_o   = IDX_W'(i);
            tgt_o   = tgt_v[i];
            attr_o  = attr_v[i];
            xaddr_o = xaddr_v[i];
         end
      end
   end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 2,
   parameter int ADDR_W    = 32,
   parameter int GRAN_W    = 16,
   parameter int TGT_W     = 7,
   parameter int ATTR_W    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(NUM_WIN)-1:0] wr_win,
   input  logic [1:0]                 wr_sel,
   input  logic [ADDR_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          lk_addr,
   output logic                       lk_hit,
   output logic                       lk_miss,
   output logic [$clog2(NUM_WIN)-1:0] lk_win,
   output logic [TGT_W-1:0]           lk_target,
   output logic [ATTR_W-1:0]          lk_attr,
   output logic [2*ADDR_W-1:0]        lk_addr_out,
   input  logic [ADDR_W-1:0]          sz_bytes,
   output logic [ADDR_W-GRAN_W-1:0]   sz_field
);
   localparam int IDX_W = $clog2(NUM_WIN);
   localparam int SZ_W  = ADDR_W - GRAN_W;
   localparam int XA_W  = 2 * ADDR_W;

   // elaboration-time parameter checks
   if (NUM_WIN < 2) begin : g_chk_win
      $error("NUM_WIN must be at least 2");
   end
   if (NUM_REMAP > NUM_WIN) begin : g_chk_remap
      $error("NUM_REMAP cannot exceed NUM_WIN");
   end
   if (GRAN_W >= ADDR_W) begin : g_chk_gran
      $error("GRAN_W must be below ADDR_W");
   end
   if (TGT_LSB + TGT_W + ATTR_W > GRAN_W) begin : g_chk_ctrl
      $error("control fields do not fit below the size mask");
   end

   logic [NUM_WIN-1:0]             hit_v;
   logic [NUM_WIN-1:0][TGT_W-1:0]  tgt_v;
   logic [NUM_WIN-1:0][ATTR_W-1:0] attr_v;
   logic [NUM_WIN-1:0][XA_W-1:0]   xaddr_v;
   logic [NUM_WIN-1:0][SZ_W-1:0]   mask_v;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic sel_w;
      assign sel_w = wr_en && (wr_win == IDX_W'(w));

      awd_window #(
         .ADDR_W (ADDR_W),
         .GRAN_W (GRAN_W),
         .TGT_W  (TGT_W),
         .ATTR_W (ATTR_W)
      ) i_window (
         .clk       (clk),
         .rst_n     (rst_n),
         .we_ctrl   (sel_w && (wr_sel == SEL_CTRL)),
         .we_base   (sel_w && (wr_sel == SEL_BASE)),
         .wdata     (wr_data),
         .addr_hi   (lk_addr[ADDR_W-1:GRAN_W]),
         .hit       (hit_v[w]),
         .size_mask (mask_v[w]),
         .tgt       (tgt_v[w]),
         .attr      (attr_v[w])
      );

      if (w < NUM_REMAP) begin : g_remap
         awd_remap #(
            .ADDR_W (ADDR_W),
            .GRAN_W (GRAN_W)
         ) i_remap (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_lo     (sel_w && (wr_sel == SEL_RLO)),
            .we_hi     (sel_w && (wr_sel == SEL_RHI)),
            .wdata     (wr_data),
            .addr      (lk_addr),
            .size_mask (mask_v[w]),
            .xaddr     (xaddr_v[w])
         );
      end else begin : g_pass
         assign xaddr_v[w] = {{ADDR_W{1'b0}}, lk_addr};
      end
   end

   awd_select #(
      .NUM_WIN (NUM_WIN),
      .TGT_W   (TGT_W),
      .ATTR_W  (ATTR_W),
      .XA_W    (XA_W)
   ) i_select (
      .hit_v   (hit_v),
      .tgt_v   (tgt_v),
      .attr_v  (attr_v),
      .xaddr_v (xaddr_v),
      .any_o   (lk_hit),
      .idx_o   (lk_win),
      .tgt_o   (lk_target),
      .attr_o  (lk_attr),
      .xaddr_o (lk_addr_out)
   );

   assign lk_miss = !lk_hit;

   awd_size_calc #(
      .ADDR_W (ADDR_W),
      .GRAN_W (GRAN_W)
   ) i_size (
      .bytes_i (sz_bytes),
      .mask_o  (sz_field)
   );
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int NUM_WIN   = 8,
   parameter int NUM_REMAP = 2,
   parameter int ADDR_W    = 32,
   parameter int GRAN_W    = 16,
   parameter int TGT_W     = 7,
   parameter int ATTR_W    = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [$clog2(NUM_WIN)-1:0] wr_win,
   input logic [1:0]                 wr_sel,
   input logic [ADDR_W-1:0]          wr_data,
   input logic [ADDR_W-1:0]          lk_addr,
   input logic                       lk_hit,
   input logic                       lk_miss,
   input logic [$clog2(NUM_WIN)-1:0] lk_win,
   input logic [TGT_W-1:0]           lk_target,
   input logic [ATTR_W-1:0]          lk_attr,
   input logic [2*ADDR_W-1:0]        lk_addr_out,
   input logic [ADDR_W-1:0]          sz_bytes,
   input logic [ADDR_W-GRAN_W-1:0]   sz_field
);
   localparam int SZ_W = ADDR_W - GRAN_W;

   // R1: while reset is held nothing decodes
   a_r1_reset_miss: assert property (@(posedge clk) !rst_n |-> lk_miss);

   // R8: hit and miss are complementary
   a_r8_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit != lk_miss);

   // R8: a miss drives every result field to zero
   a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> (lk_addr_out == '0 && lk_target == '0 && lk_attr == '0 && lk_win == '0));

   // R7: non-translating windows pass the address through
   a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && (int'(lk_win) >= NUM_REMAP)) |-> (lk_addr_out == {{ADDR_W{1'b0}}, lk_addr}));

   // R6: translation keeps the offset inside a 64 KiB granule
   a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_addr_out[GRAN_W-1:0] == lk_addr[GRAN_W-1:0]));

   // R9: a window whose control was cleared cannot win in the next cycle
   a_r9_cleared_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && wr_data == '0)
      |=> !(lk_hit && lk_win == $past(wr_win)));

   // R10: the size helper always yields a run of ones from bit 0
   a_r10_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
      (sz_field & SZ_W'(sz_field + 1'b1)) == '0);

   // R10: counts up to one granule give the smallest window
   a_r10_one_granule: assert property (@(posedge clk) disable iff (!rst_n)
      (sz_bytes != '0 && sz_bytes <= (ADDR_W'(1) << GRAN_W)) |-> (sz_field == '0));
endmodule

bind addr_window_decoder awd_checker #(
   .NUM_WIN   (NUM_WIN),
   .NUM_REMAP (NUM_REMAP),
   .ADDR_W    (ADDR_W),
   .GRAN_W    (GRAN_W),
   .TGT_W     (TGT_W),
   .ATTR_W    (ATTR_W)
) i_awd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_win      (wr_win),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .lk_addr     (lk_addr),
   .lk_hit      (lk_hit),
   .lk_miss     (lk_miss),
   .lk_win      (lk_win),
   .lk_target   (lk_target),
   .lk_attr     (lk_attr),
   .lk_addr_out (lk_addr_out),
   .sz_bytes    (sz_bytes),
   .sz_field    (sz_field)
);

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_win = '0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] lk_addr = '0;
   logic        lk_hit, lk_miss;
   logic [2:0]  lk_win;
   logic [6:0]  lk_target;
   logic [7:0]  lk_attr;
   logic [63:0] lk_addr_out;
   logic [31:0] sz_bytes = '0;
   logic [15:0] sz_field;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   // bench model of the programmed registers
   logic [31:0] m_ctrl [8];
   logic [31:0] m_base [8];
   logic [31:0] m_rlo  [2];
   logic [31:0] m_rhi  [2];

   always #(CLK_P/2) clk = ~clk;

   addr_window_decoder i_addr_window_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
      .wr_data(wr_data), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_miss(lk_miss),
      .lk_win(lk_win), .lk_target(lk_target), .lk_attr(lk_attr),
      .lk_addr_out(lk_addr_out), .sz_bytes(sz_bytes), .sz_field(sz_field)
   );

   // expected lookup result: {hit, miss, win, target, attr, address}
   function automatic logic [83:0] exp_lookup(logic [31:0] a);
      logic [83:0] r;
      logic [15:0] sz;
      logic [63:0] x;
      r = {1'b0, 1'b1, 82'b0};
      for (int w = 7; w >= 0; w--) begin
         sz = m_ctrl[w][31:16];
         if (m_ctrl[w][0] && ((a[31:16] & ~sz) == (m_base[w][31:16] & ~sz))) begin
            if (w < 2) x = {m_rhi[w], (m_rlo[w][31:16] & ~sz) | (a[31:16] & sz), a[15:0]};
            else       x = {32'h0, a};
            r = {1'b1, 1'b0, 3'(w), m_ctrl[w][7:1], m_ctrl[w][15:8], x};
         end
      end
      return r;
   endfunction

   // expected size mask: smallest all-ones value not below granules-1
   function automatic logic [15:0] exp_size(logic [31:0] b);
      logic [32:0] gran;
      logic [32:0] f;
      if (b == 0) return 16'hFFFF;
      gran = ({1'b0, b} + 33'd65535) >> 16;
      f = 0;
      while (f < gran - 1) f = (f << 1) | 33'd1;
      return f[15:0];
   endfunction

   function automatic logic [31:0] ctrl_word(logic en, logic [6:0] t, logic [7:0] at,
                                             logic [15:0] sz);
      return {sz, at, t, en};
   endfunction

   function automatic logic [83:0] act_lookup();
      return {lk_hit, lk_miss, lk_win, lk_target, lk_attr, lk_addr_out};
   endfunction

   task automatic compare(string tag, logic [83:0] act, logic [83:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // present an address and compare against the model in the same cycle
   task automatic lookup(logic [31:0] a, string tag);
      logic [83:0] e;
      lk_addr = a;
      #1;
      e = exp_lookup(a);
      if (tag == "") tag = e[82] ? "R8" : (e[80:78] < 3'd2 ? "R6" : "R3");
      compare(tag, act_lookup(), e);
   endtask

   task automatic size_check(logic [31:0] b);
      sz_bytes = b;
      #1;
      compare("R10", {68'b0, sz_field}, {68'b0, exp_size(b)});
   endtask

   task automatic model_write(logic [2:0] w, logic [1:0] s, logic [31:0] d);
      case (s)
         2'd0: m_ctrl[w] = d;
         2'd1: m_base[w] = d;
         2'd2: if (w < 2) m_rlo[w] = d;
         default: if (w < 2) m_rhi[w] = d;
      endcase
   endtask

   // drive one write after a falling edge; the rising edge in between takes it
   task automatic wr(logic [2:0] w, logic [1:0] s, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_win = w; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(w, s, d);
   endtask

   function automatic logic [15:0] thermo(int k);
      return 16'((32'd1 << k) - 1);
   endfunction

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) begin m_ctrl[i] = '0; m_base[i] = '0; end
      for (int i = 0; i < 2; i++) begin m_rlo[i] = '0; m_rhi[i] = '0; end

      repeat (3) @(negedge clk);
      // R1: everything disabled while and after reset
      lookup(32'h0000_0000, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      lookup(32'h0000_0000, "R1");
      lookup(32'hFFFF_FFFF, "R1");
      lookup(32'h8123_4567, "R8");

      // R10: size helper corners
      size_check(32'd0);
      size_check(32'd1);
      size_check(32'h0001_0000);
      size_check(32'h0001_0001);
      size_check(32'h0100_0000);
      size_check(32'h0100_0001);
      size_check(32'h8000_0000);
      size_check(32'hFFFF_FFFF);

      // R2: the write is invisible before the capturing edge, visible after it
      wr(3'd4, 2'd1, 32'h1000_0000);
      @(negedge clk);
      wr_en = 1'b1; wr_win = 3'd4; wr_sel = 2'd0;
      wr_data = ctrl_word(1'b1, 7'd5, 8'h3C, 16'h00FF);
      lookup(32'h1000_0010, "R2");
      @(negedge clk);
      wr_en = 1'b0;
      model_write(3'd4, 2'd0, ctrl_word(1'b1, 7'd5, 8'h3C, 16'h00FF));
      lookup(32'h1000_0010, "R2");

      // R4: 16 MiB window edges
      lookup(32'h10FF_FFFF, "R4");
      lookup(32'h1100_0000, "R4");
      lookup(32'h0FFF_FFFF, "R4");
      // R4: an all-zero mask covers exactly 64 KiB; R3 low base bits ignored
      wr(3'd5, 2'd1, 32'h2000_ABCD);
      wr(3'd5, 2'd0, ctrl_word(1'b1, 7'd9, 8'h11, 16'h0000));
      lookup(32'h2000_0000, "R4");
      lookup(32'h2000_FFFF, "R3");
      lookup(32'h2001_0000, "R4");

      // R11 and R5: two windows on the same range, lower number wins
      wr(3'd6, 2'd1, 32'hFF00_0000);
      wr(3'd6, 2'd0, ctrl_word(1'b1, 7'd1, 8'hA5, 16'h00FF));
      wr(3'd7, 2'd1, 32'hFF00_0000);
      wr(3'd7, 2'd0, ctrl_word(1'b1, 7'd1, 8'h5A, 16'h00FF));
      lookup(32'hFF12_3456, "R5");
      // R9 and R11: clearing the lower window hands over to the higher
      wr(3'd6, 2'd0, 32'h0);
      lookup(32'hFF12_3456, "R11");
      wr(3'd7, 2'd0, 32'h0);
      lookup(32'hFF12_3456, "R9");
      wr(3'd6, 2'd1, 32'h3000_0000);
      wr(3'd6, 2'd0, ctrl_word(1'b1, 7'd2, 8'h77, 16'h0003));
      lookup(32'h3003_0000, "R3");
      // R5: a large low window shadows window 4
      wr(3'd2, 2'd1, 32'h0000_0000);
      wr(3'd2, 2'd0, ctrl_word(1'b1, 7'd3, 8'h01, 16'h1FFF));
      lookup(32'h1080_0000, "R5");

      // R6: translation through window 0
      wr(3'd0, 2'd1, 32'h8000_0000);
      wr(3'd0, 2'd2, 32'h4000_0000);
      wr(3'd0, 2'd3, 32'h0000_0001);
      wr(3'd0, 2'd0, ctrl_word(1'b1, 7'd10, 8'hC0, 16'h0FFF));
      lookup(32'h8123_4567, "R6");
      lookup(32'h8FFF_FFFF, "R6");
      // R6: identity remap on window 1
      wr(3'd1, 2'd1, 32'hC000_0000);
      wr(3'd1, 2'd2, 32'hC000_0000);
      wr(3'd1, 2'd0, ctrl_word(1'b1, 7'd11, 8'hC1, 16'h00FF));
      lookup(32'hC0AB_CDEF, "R6");

      // R7: remap writes to a plain window have no effect
      wr(3'd3, 2'd1, 32'h5000_0000);
      wr(3'd3, 2'd0, ctrl_word(1'b1, 7'd4, 8'h44, 16'h000F));
      wr(3'd3, 2'd2, 32'h1234_0000);
      wr(3'd3, 2'd3, 32'hDEAD_BEEF);
      lookup(32'h5007_1234, "R7");

      // random phase
      for (int it = 0; it < 600; it++) begin
         r = $urandom;
         if (r[2:0] < 3'd2) begin
            logic [2:0] w;
            logic [1:0] s;
            logic [31:0] d;
            w = 3'($urandom);
            s = 2'($urandom);
            d = $urandom;
            if (s == 2'd0)
               d = ctrl_word(($urandom % 4) != 0, 7'($urandom), 8'($urandom),
                             thermo(int'($urandom % 17)));
            wr(w, s, d);
         end else begin
            logic [31:0] a;
            a = {m_base[3'($urandom)][31:16], 16'($urandom)};
            if (r[5:3] == 3'd0) a = $urandom;
            else a[31:16] = a[31:16] ^ (16'($urandom) & {12'h0, r[9:6]});
            lookup(a, "");
         end
         if (r[12:10] == 3'd0) size_check($urandom >> ($urandom % 32));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule